// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block sits between an 8-bit processor bus with a 16-bit address and the ROM and battery-backed RAM of a plug-in cartridge. A processor write anywhere in the lower 32 KB is never stored in ROM. It is decoded as a write to one of four control registers: RAM enable, low ROM bank bits, a 2-bit upper/RAM bank register, and the banking mode. The controller turns these into a physical ROM address for the switchable 16 KB window at 0x4000–0x7FFF and a physical RAM address for the 8 KB window at 0xA000–0xBFFF.

The bank number never lands on a bank whose low five bits are all zero. The mode bit decides whether the 2-bit register extends the ROM bank or selects one of the RAM banks. Configuration inputs give the ROM bank count, the RAM bank count and a RAM size code. All accesses outside the two windows and the control range are passed unchanged to a default bus port.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write to 0x0000–0x1FFF sets RAM enable to (data[3:0] == 0xA). Any other low nibble clears it. The write has no effect when the RAM size code is 0. Size codes: 0 none, 1 2 KB, 2 8 KB, 3 32 KB.
- R2: A write to 0x2000–0x3FFF updates the ROM bank. In mode 0 the new bank is {upper[1:0], data[4:0]}. In mode 1 it is data[4:0] alone.
- R3: Every ROM bank update adds one when bits 4:0 of the computed bank are zero (0x00, 0x20, 0x40, 0x60). The result is then ANDed with (ROM bank count − 1).
- R4: A write to 0x4000–0x5FFF behaves by mode. In mode 1, data[1:0] AND (RAM bank count − 1) becomes the RAM bank. In mode 0, data[1:0] becomes the upper bits and the ROM bank is recomputed at once as {upper, bank[4:0]}, with R3 applied.
- R5: A write to 0x6000–0x7FFF sets the mode to data[0]. A request for mode 1 is ignored unless the RAM size code is 3.
- R6: A read in 0x4000–0x7FFF asserts the ROM read strobe, drives ROM address bank·0x4000 + addr[13:0], and returns the ROM data.
- R7: An access in 0xA000–0xBFFF uses RAM address addr[12:0] in mode 0, and RAM bank·0x2000 + addr[12:0] in mode 1.
- R8: While RAM is disabled, a read in 0xA000–0xBFFF returns 0xFF with no RAM strobe, and a write there asserts no RAM write.
- R9: After reset the mode is 0, the ROM bank is 1, the RAM bank is 0, the upper bits are 0 and RAM is disabled.
- R10: The out-of-range flag is high for an enabled mode 0 RAM access at 0xA800 or above while the size code is 1. It is low otherwise.
- R11: A RAM-enable write that turns an enabled RAM off raises the disable pulse for exactly one cycle after the write edge.
- R12: Accesses outside 0x4000–0x7FFF, 0xA000–0xBFFF and writes below 0x8000 go to the default port with address and data unchanged and return its read data. At most one of the five strobes is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Bus address |
| wdata_i | input | 8 | Bus write data |
| wr_i | input | 1 | Bus write strobe |
| rd_i | input | 1 | Bus read strobe |
| rdata_o | output | 8 | Bus read data |
| rom_bank_cnt_i | input | ROM_BANK_W+1 | Number of ROM banks (power of two) |
| ram_bank_cnt_i | input | RAM_BANK_W+1 | Number of RAM banks (power of two) |
| ram_size_i | input | 2 | RAM size code |
| rom_addr_o | output | ROM_BANK_W+14 | Physical ROM address |
| rom_re_o | output | 1 | ROM read strobe |
| rom_rdata_i | input | 8 | ROM read data |
| ram_addr_o | output | RAM_BANK_W+13 | Physical RAM address |
| ram_re_o | output | 1 | RAM read strobe |
| ram_we_o | output | 1 | RAM write strobe |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data |
| ram_oor_o | output | 1 | RAM access beyond a 2 KB part |
| ram_off_o | output | 1 | One-cycle pulse when RAM is disabled |
| dflt_addr_o | output | 16 | Default port address |
| dflt_wdata_o | output | 8 | Default port write data |
| dflt_re_o | output | 1 | Default port read strobe |
| dflt_we_o | output | 1 | Default port write strobe |
| dflt_rdata_i | input | 8 | Default port read data |

## Verification
The assertions assume that the bank counts are powers of two and that the configuration inputs change only while reset is held. The bank-never-zero property depends on both. The stimulus therefore changes configuration only through a reset sequence. Reads and writes are never issued in the same cycle, because the one-hot strobe check relies on that.

// File: rtl/cart_bank_pkg.sv
`timescale 1ns/1ps
package cart_bank_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int LOW_W  = 5;

  // window number is addr[15:13]
  typedef enum logic [2:0] {
    WIN_RAMEN  = 3'd0,
    WIN_BANKLO = 3'd1,
    WIN_BANKHI = 3'd2,
    WIN_MODE   = 3'd3,
    WIN_VID    = 3'd4,
    WIN_XRAM   = 3'd5,
    WIN_WORK   = 3'd6,
    WIN_TOP    = 3'd7
  } win_e;

  typedef enum logic [1:0] {
    RAMSZ_NONE = 2'd0,
    RAMSZ_2K   = 2'd1,
    RAMSZ_8K   = 2'd2,
    RAMSZ_32K  = 2'd3
  } ramsz_e;
endpackage

// File: rtl/cart_bank_regs.sv
`timescale 1ns/1ps
module cart_bank_regs
  import cart_bank_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  win_e                    win_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [ROM_BANK_W:0]     rom_cnt_i,
  input  logic [RAM_BANK_W:0]     ram_cnt_i,
  input  logic [1:0]              ram_size_i,
  output logic [ROM_BANK_W-1:0]   rom_bank_o,
  output logic [RAM_BANK_W-1:0]   ram_bank_o,
  output logic                    mode_o,
  output logic                    ram_en_o,
  output logic                    ram_off_o
);
  localparam int UPPER_W = ROM_BANK_W - LOW_W;

  logic [ROM_BANK_W-1:0] rom_bank_q, raw_bank, fix_bank, rom_mask;
  logic [UPPER_W-1:0]    upper_q, upper_sel;
  logic [LOW_W-1:0]      low_sel;
  logic [RAM_BANK_W-1:0] ram_bank_q, ram_mask;
  logic                  mode_q, en_q, off_q, en_next;
  logic                  wr_en, wr_lo, wr_hi, wr_mode, bank_upd;
  logic [ROM_BANK_W:0]   rom_cnt_m1;
  logic [RAM_BANK_W:0]   ram_cnt_m1;

  assign wr_en   = wr_i && (win_i == WIN_RAMEN) && (ram_size_i != RAMSZ_NONE);
  assign wr_lo   = wr_i && (win_i == WIN_BANKLO);
  assign wr_hi   = wr_i && (win_i == WIN_BANKHI);
  assign wr_mode = wr_i && (win_i == WIN_MODE)
                   && !(wdata_i[0] && (ram_size_i != RAMSZ_32K));
  assign bank_upd = wr_lo || (wr_hi && !mode_q);
  assign en_next  = (wdata_i[3:0] == 4'hA);

  assign rom_cnt_m1 = rom_cnt_i - 1'b1;
  assign ram_cnt_m1 = ram_cnt_i - 1'b1;
  assign rom_mask   = rom_cnt_m1[ROM_BANK_W-1:0];
  assign ram_mask   = ram_cnt_m1[RAM_BANK_W-1:0];

  always_comb begin
    low_sel   = wr_lo ? wdata_i[LOW_W-1:0] : rom_bank_q[LOW_W-1:0];
    upper_sel = wr_hi ? wdata_i[UPPER_W-1:0] : upper_q;
    if (mode_q) raw_bank = {{UPPER_W{1'b0}}, low_sel};
    else        raw_bank = {upper_sel, low_sel};
    // skip any bank whose low five bits are zero
    fix_bank = raw_bank + {{(ROM_BANK_W-1){1'b0}}, (raw_bank[LOW_W-1:0] == '0)};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rom_bank_q <= {{(ROM_BANK_W-1){1'b0}}, 1'b1};
      upper_q    <= '0;
      ram_bank_q <= '0;
      mode_q     <= 1'b0;
      en_q       <= 1'b0;
      off_q      <= 1'b0;
    end else begin
      off_q <= wr_en && en_q && !en_next;
      if (wr_en)    en_q <= en_next;
      if (wr_mode)  mode_q <= wdata_i[0];
      if (bank_upd) rom_bank_q <= fix_bank & rom_mask;
      if (wr_hi && !mode_q) upper_q <= wdata_i[UPPER_W-1:0];
      if (wr_hi && mode_q)  ram_bank_q <= wdata_i[RAM_BANK_W-1:0] & ram_mask;
    end
  end

  assign rom_bank_o = rom_bank_q;
  assign ram_bank_o = ram_bank_q;
  assign mode_o     = mode_q;
  assign ram_en_o   = en_q;
  assign ram_off_o  = off_q;
endmodule

// File: rtl/cart_bank_map.sv
`timescale 1ns/1ps
module cart_bank_map
  import cart_bank_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2,
  localparam int ROM_AW = ROM_BANK_W + 14,
  localparam int RAM_AW = RAM_BANK_W + 13
) (
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [ROM_BANK_W-1:0] rom_bank_i,
  input  logic [RAM_BANK_W-1:0] ram_bank_i,
  input  logic                  mode_i,
  input  logic                  ram_en_i,
  input  logic                  ram_acc_i,
  input  logic [1:0]            ram_size_i,
  output logic [ROM_AW-1:0]     rom_addr_o,
  output logic [RAM_AW-1:0]     ram_addr_o,
  output logic                  ram_oor_o
);
  assign rom_addr_o = {rom_bank_i, addr_i[13:0]};
  assign ram_addr_o = mode_i ? {ram_bank_i, addr_i[12:0]}
                             : {{RAM_BANK_W{1'b0}}, addr_i[12:0]};
  // beyond 0x7FF inside the window on a 2 KB part
  assign ram_oor_o  = ram_acc_i && ram_en_i && !mode_i
                      && (ram_size_i == RAMSZ_2K) && (addr_i[12:11] != 2'b00);
endmodule

// File: rtl/cart_bank_bus.sv
`timescale 1ns/1ps
module cart_bank_bus
  import cart_bank_pkg::*;
(
  input  logic              rd_i,
  input  logic              wr_i,
  input  win_e              win_i,
  input  logic              ram_en_i,
  input  logic [DATA_W-1:0] rom_rdata_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  input  logic [DATA_W-1:0] dflt_rdata_i,
  output logic              rom_re_o,
  output logic              ram_re_o,
  output logic              ram_we_o,
  output logic              dflt_re_o,
  output logic              dflt_we_o,
  output logic              ram_acc_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic is_rom, is_ram, is_ctl;

  assign is_rom = (win_i == WIN_BANKHI) || (win_i == WIN_MODE);
  assign is_ram = (win_i == WIN_XRAM);
  assign is_ctl = !win_i[2];

  assign ram_acc_o = is_ram && (rd_i || wr_i);
  assign rom_re_o  = rd_i && is_rom;
  assign ram_re_o  = rd_i && is_ram && ram_en_i;
  assign ram_we_o  = wr_i && is_ram && ram_en_i;
  assign dflt_re_o = rd_i && !is_rom && !is_ram;
  assign dflt_we_o = wr_i && !is_ctl && !is_ram;

  always_comb begin
    if (is_rom)      rdata_o = rom_rdata_i;
    else if (is_ram) rdata_o = ram_en_i ? ram_rdata_i : {DATA_W{1'b1}};
    else             rdata_o = dflt_rdata_i;
  end
endmodule

// File: rtl/cart_bank_ctrl.sv
`timescale 1ns/1ps
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2,
  localparam int ROM_AW = ROM_BANK_W + 14,
  localparam int RAM_AW = RAM_BANK_W + 13
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic [ROM_BANK_W:0]   rom_bank_cnt_i,
  input  logic [RAM_BANK_W:0]   ram_bank_cnt_i,
  input  logic [1:0]            ram_size_i,
  output logic [ROM_AW-1:0]     rom_addr_o,
  output logic                  rom_re_o,
  input  logic [DATA_W-1:0]     rom_rdata_i,
  output logic [RAM_AW-1:0]     ram_addr_o,
  output logic                  ram_re_o,
  output logic                  ram_we_o,
  output logic [DATA_W-1:0]     ram_wdata_o,
  input  logic [DATA_W-1:0]     ram_rdata_i,
  output logic                  ram_oor_o,
  output logic                  ram_off_o,
  output logic [ADDR_W-1:0]     dflt_addr_o,
  output logic [DATA_W-1:0]     dflt_wdata_o,
  output logic                  dflt_re_o,
  output logic                  dflt_we_o,
  input  logic [DATA_W-1:0]     dflt_rdata_i
);
  win_e                  win;
  logic [ROM_BANK_W-1:0] rom_bank;
  logic [RAM_BANK_W-1:0] ram_bank;
  logic                  mode, ram_en, ram_acc;

  assign win = win_e'(addr_i[ADDR_W-1:ADDR_W-3]);

  cart_bank_regs #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .win_i      (win),
    .wdata_i    (wdata_i),
    .rom_cnt_i  (rom_bank_cnt_i),
    .ram_cnt_i  (ram_bank_cnt_i),
    .ram_size_i (ram_size_i),
    .rom_bank_o (rom_bank),
    .ram_bank_o (ram_bank),
    .mode_o     (mode),
    .ram_en_o   (ram_en),
    .ram_off_o  (ram_off_o)
  );

  cart_bank_map #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) i_map (
    .addr_i     (addr_i),
    .rom_bank_i (rom_bank),
    .ram_bank_i (ram_bank),
    .mode_i     (mode),
    .ram_en_i   (ram_en),
    .ram_acc_i  (ram_acc),
    .ram_size_i (ram_size_i),
    .rom_addr_o (rom_addr_o),
    .ram_addr_o (ram_addr_o),
    .ram_oor_o  (ram_oor_o)
  );

  cart_bank_bus i_bus (
    .rd_i         (rd_i),
    .wr_i         (wr_i),
    .win_i        (win),
    .ram_en_i     (ram_en),
    .rom_rdata_i  (rom_rdata_i),
    .ram_rdata_i  (ram_rdata_i),
    .dflt_rdata_i (dflt_rdata_i),
    .rom_re_o     (rom_re_o),
    .ram_re_o     (ram_re_o),
    .ram_we_o     (ram_we_o),
    .dflt_re_o    (dflt_re_o),
    .dflt_we_o    (dflt_we_o),
    .ram_acc_o    (ram_acc),
    .rdata_o      (rdata_o)
  );

  assign ram_wdata_o  = wdata_i;
  assign dflt_addr_o  = addr_i;
  assign dflt_wdata_o = wdata_i;
endmodule

// File: rtl/cart_bank_chk.sv
`timescale 1ns/1ps
module cart_bank_chk #(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2,
  localparam int ROM_AW = ROM_BANK_W + 14,
  localparam int RAM_AW = RAM_BANK_W + 13
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [15:0]         addr_i,
  input logic [7:0]          wdata_i,
  input logic                wr_i,
  input logic                rd_i,
  input logic [7:0]          rdata_o,
  input logic [ROM_BANK_W:0] rom_bank_cnt_i,
  input logic [1:0]          ram_size_i,
  input logic [ROM_AW-1:0]   rom_addr_o,
  input logic                rom_re_o,
  input logic [RAM_AW-1:0]   ram_addr_o,
  input logic                ram_re_o,
  input logic                ram_we_o,
  input logic                ram_off_o,
  input logic                dflt_re_o,
  input logic                dflt_we_o
);
  // R1
  ram_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[15:13] == 3'd0 && ram_size_i != 2'd0 && wdata_i[3:0] != 4'hA)
    |=> !ram_we_o && !ram_re_o);

  // R8
  ram_idle_ff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[15:13] == 3'd5 && !ram_re_o) |-> rdata_o == 8'hFF);

  // R5
  mode_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[15:13] == 3'd3 && wdata_i[0] && ram_size_i != 2'd3)
    |=> $stable(ram_addr_o[RAM_AW-1:13]));

  // R11
  off_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_off_o |=> !ram_off_o);

  // R3
  bank_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_bank_cnt_i >= 32) |-> rom_addr_o[18:14] != 5'd0);

  // R12
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rom_re_o, ram_re_o, ram_we_o, dflt_re_o, dflt_we_o}));
endmodule

bind cart_bank_ctrl cart_bank_chk #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .addr_i         (addr_i),
  .wdata_i        (wdata_i),
  .wr_i           (wr_i),
  .rd_i           (rd_i),
  .rdata_o        (rdata_o),
  .rom_bank_cnt_i (rom_bank_cnt_i),
  .ram_size_i     (ram_size_i),
  .rom_addr_o     (rom_addr_o),
  .rom_re_o       (rom_re_o),
  .ram_addr_o     (ram_addr_o),
  .ram_re_o       (ram_re_o),
  .ram_we_o       (ram_we_o),
  .ram_off_o      (ram_off_o),
  .dflt_re_o      (dflt_re_o),
  .dflt_we_o      (dflt_we_o)
);

// File: tb/test_cart_bank_ctrl.sv
`timescale 1ns/1ps
module test_cart_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata;
  logic [7:0]  rom_cnt = 8'd128;
  logic [2:0]  ram_cnt = 3'd4;
  logic [1:0]  ram_sz = 2'd3;
  logic [20:0] rom_addr;
  logic        rom_re;
  logic [7:0]  rom_rdata = 8'h3C;
  logic [14:0] ram_addr;
  logic        ram_re, ram_we, ram_oor, ram_off;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_rdata = 8'h5A;
  logic [15:0] dflt_addr;
  logic [7:0]  dflt_wdata;
  logic        dflt_re, dflt_we;
  logic [7:0]  dflt_rdata = 8'hC3;

  int checks = 0, fails = 0;
  int m_mode, m_bank, m_upper, m_rbank, m_en;

  always #4 clk = ~clk;

  cart_bank_ctrl i_cart_bank_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .rom_bank_cnt_i(rom_cnt), .ram_bank_cnt_i(ram_cnt),
    .ram_size_i(ram_sz), .rom_addr_o(rom_addr), .rom_re_o(rom_re),
    .rom_rdata_i(rom_rdata), .ram_addr_o(ram_addr), .ram_re_o(ram_re),
    .ram_we_o(ram_we), .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata),
    .ram_oor_o(ram_oor), .ram_off_o(ram_off), .dflt_addr_o(dflt_addr),
    .dflt_wdata_o(dflt_wdata), .dflt_re_o(dflt_re), .dflt_we_o(dflt_we),
    .dflt_rdata_i(dflt_rdata)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int fixb(int raw);
    int r = raw;
    if ((r & 31) == 0) r++;
    return r & (int'(rom_cnt) - 1);
  endfunction

  task automatic restart(int rc, int bc, int sz);
    @(negedge clk);
    rst_n = 1'b0; rom_cnt = 8'(rc); ram_cnt = 3'(bc); ram_sz = 2'(sz);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_mode = 0; m_bank = 1; m_upper = 0; m_rbank = 0; m_en = 0;
  endtask

  // bus write plus reference update from the requirements
  task automatic bw(int a, int d);
    @(negedge clk);
    addr = 16'(a); wdata = 8'(d); wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    case (a >> 13)
      0: if (ram_sz != 0) m_en = ((d & 15) == 10) ? 1 : 0;
      1: m_bank = fixb(m_mode != 0 ? (d & 31) : ((d & 31) | (m_upper << 5)));
      2: if (m_mode != 0) m_rbank = d & 3 & (int'(ram_cnt) - 1);
         else begin
           m_upper = d & 3;
           m_bank = fixb((m_bank & 31) | (m_upper << 5));
         end
      3: if (!(ram_sz != 3 && (d & 1) != 0)) m_mode = d & 1;
      default: ;
    endcase
  endtask

  task automatic rom_rd(string tag, int off);
    @(negedge clk);
    addr = 16'(16'h4000 + off); rd = 1'b1;
    #1;
    chk(tag, int'(rom_addr), m_bank * 16384 + off);
    rd = 1'b0;
  endtask

  task automatic ram_rd(string tag, int a);
    @(negedge clk);
    addr = 16'(a); rd = 1'b1;
    #1;
    if (m_en != 0) begin
      chk(tag, int'(ram_addr), (m_mode != 0 ? m_rbank * 8192 : 0) + (a - 16'hA000));
      chk(tag, int'(rdata), 8'h5A);
    end else begin
      chk(tag, int'(rdata), 8'hFF);
      chk(tag, int'(ram_re), 0);
    end
    rd = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    restart(128, 4, 3);
    // R9 reset state
    rom_rd("R9 bank1", 16'h0123);
    ram_rd("R9 ram off", 16'hA010);
    chk("R9 off pulse", int'(ram_off), 0);
    bw(16'h4000, 2); bw(16'h6000, 1); // mode 1 reachable, RAM bank 0
    ram_rd("R9 ram disabled", 16'hA000);
    restart(128, 4, 3);

    // R2 R3 mode 0 full sweep
    for (int u = 0; u < 4; u++)
      for (int d = 0; d < 32; d++) begin
        bw(16'h4000, u);
        bw(16'h2000, d | 8'hE0);
        rom_rd("R2 R3 mode0 sweep", (d * 517) & 16'h3FFF);
      end

    // R4 immediate recompute from the upper write
    bw(16'h2000, 0); bw(16'h4000, 2);
    rom_rd("R4 upper recompute 0x41", 5);
    bw(16'h4000, 1);
    rom_rd("R4 upper recompute 0x21", 6);
    bw(16'h2000, 5); bw(16'h4000, 3);
    rom_rd("R4 upper recompute 0x65", 7);

    // R6 strobe and data
    @(negedge clk); addr = 16'h7FFF; rd = 1'b1; #1;
    chk("R6 rom strobe", int'(rom_re), 1);
    chk("R6 rom data", int'(rdata), 8'h3C);
    chk("R6 rom addr", int'(rom_addr), m_bank * 16384 + 16'h3FFF);
    rd = 1'b0;

    // R1 enable by low nibble
    bw(16'h0000, 8'h1A);
    ram_rd("R1 enable 0x1A", 16'hA7F0);
    chk("R1 model enabled", m_en, 1);
    bw(16'h1FFF, 8'hA0);
    ram_rd("R1 disable 0xA0", 16'hA001);
    bw(16'h0000, 8'h0A);
    ram_rd("R1 enable 0x0A", 16'hBFFF);

    // R11 pulse on disable
    bw(16'h0000, 8'h0B);
    chk("R11 pulse high", int'(ram_off), 1);
    @(negedge clk);
    chk("R11 pulse one cycle", int'(ram_off), 0);
    bw(16'h0000, 8'h00);
    chk("R11 no pulse when already off", int'(ram_off), 0);

    // R8 disabled write dropped
    @(negedge clk); addr = 16'hA123; wdata = 8'h77; wr = 1'b1; #1;
    chk("R8 write dropped", int'(ram_we), 0);
    @(negedge clk); wr = 1'b0;

    // R5 R7 R4 mode 1 with four RAM banks
    bw(16'h0000, 8'h0A);
    bw(16'h6000, 1);
    for (int b = 0; b < 4; b++) begin
      bw(16'h4000, b);
      ram_rd("R7 R4 mode1 ram bank", 16'hA000 + b * 16'h0511);
    end
    @(negedge clk); addr = 16'hB000; wdata = 8'h99; wr = 1'b1; #1;
    chk("R7 write strobe", int'(ram_we), 1);
    chk("R7 write data", int'(ram_wdata), 8'h99);
    @(negedge clk); wr = 1'b0;
    // R2 mode 1 ignores upper
    for (int d = 0; d < 32; d++) begin
      bw(16'h2000, d);
      rom_rd("R2 R3 mode1 sweep", d * 3);
    end
    bw(16'h6000, 0);
    ram_rd("R7 mode0 ignores ram bank", 16'hA456);

    // R4 RAM bank mask with two banks
    restart(128, 2, 3);
    bw(16'h0000, 8'h0A); bw(16'h6000, 1); bw(16'h4000, 3);
    ram_rd("R4 ram mask", 16'hA100);

    // R3 ROM count mask
    restart(16, 4, 3);
    bw(16'h2000, 8'h13);
    rom_rd("R3 mask 16 -> 3", 9);
    bw(16'h2000, 8'h00);
    rom_rd("R3 skip then mask", 9);

    // R5 refused mode change on 2 KB and 8 KB parts
    for (int sz = 1; sz < 3; sz++) begin
      restart(128, 4, sz);
      bw(16'h6000, 1);
      bw(16'h4000, 2); bw(16'h2000, 3);
      rom_rd("R5 refused mode keeps 0x43", 1);
      chk("R5 model bank", m_bank, 8'h43);
    end

    // R1 ignored with no RAM
    restart(128, 4, 0);
    bw(16'h0000, 8'h0A);
    ram_rd("R1 no ram ignore", 16'hA000);

    // R10 range flag on 2 KB part
    restart(128, 1, 1);
    bw(16'h0000, 8'h0A);
    @(negedge clk); addr = 16'hA800; rd = 1'b1; #1;
    chk("R10 flag at 0xA800", int'(ram_oor), 1);
    addr = 16'hA7FF; #1;
    chk("R10 clear at 0xA7FF", int'(ram_oor), 0);
    addr = 16'hBFFF; #1;
    chk("R10 flag at 0xBFFF", int'(ram_oor), 1);
    rd = 1'b0; #1;
    chk("R10 clear idle", int'(ram_oor), 0);

    // R12 pass-through
    @(negedge clk); addr = 16'h0123; rd = 1'b1; #1;
    chk("R12 bank0 read strobe", int'(dflt_re), 1);
    chk("R12 bank0 data", int'(rdata), 8'hC3);
    chk("R12 addr", int'(dflt_addr), 16'h0123);
    rd = 1'b0;
    @(negedge clk); addr = 16'hC456; wdata = 8'h21; wr = 1'b1; #1;
    chk("R12 work write", int'(dflt_we), 1);
    chk("R12 work data", int'(dflt_wdata), 8'h21);
    addr = 16'h2000; #1;
    chk("R12 control write not passed", int'(dflt_we), 0);
    addr = 16'h8001; #1;
    chk("R12 video write", int'(dflt_we), 1);
    @(negedge clk); wr = 1'b0;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule